// File: doc/BRIEF.md
# NCO Phase and Frequency Control

This block generates the 32-bit phase argument that drives the sine/cosine lookup of a numerically controlled oscillator. Two frequency registers, a center value and an offset value, are summed into a phase step that is added to a wrapping 32-bit phase accumulator on every clock edge. The step for a wanted output frequency is (f_out / f_clk) × 2^32, and a full sweep of the phase word from 0 to 2^32−1 is one counterclockwise turn that starts at 0 degrees. A 16-bit phase offset is added to the upper half of the accumulated phase, which allows phase-shift keying. The offset comes either from a host-written phase register or from two symbol pins that select one of four quadrants.

The host loads values over a 16-bit bus into three staging registers: the low frequency half, the high frequency half and the phase word. A separate active-low enable for each target register is registered once before use. A target register therefore loads one edge after its enable is sampled, and it keeps reloading from staging for as long as that enable stays low. The accumulator overflow is inverted and brought out as an active-low carry.

Top module: `nco_phase_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the accumulator, the staging registers and the center, offset and phase registers. While reset is held and at the first edge after it, phase_arg reads 0 and acc_carry_n reads 1.
- R2: A host write takes place at a rising edge where host_sel_n and host_wr_n are both low. Address 0 writes the low frequency half, 1 writes the high frequency half and 2 writes the phase staging word. Address 3 and any edge with host_sel_n high leave all staging registers unchanged.
- R3: A load enable that is low at edge k loads its target at edge k+1. The accumulator first uses the new value at edge k+2, and phase_arg shows it after edge k+3. A register whose registered enable is high keeps its value.
- R4: While a load enable is held low, its target register reloads from staging at every edge, so a new host write reaches it without a further pulse.
- R5: At each edge the accumulator adds center + offset (modulo 2^32) and keeps the 32-bit wrapped sum.
- R6: acc_carry_n is registered together with the accumulator. It is 0 for the cycle after an edge whose addition overflowed and 1 otherwise, so it runs one cycle ahead of the matching wrap in phase_arg.
- R7: phase_arg is registered. After each edge it equals the accumulator value from before that edge plus the phase register shifted left by 16, modulo 2^32.
- R8: With ph_mode = 1, a phase load copies the 16-bit phase staging word into the phase register.
- R9: With ph_mode = 0, a phase load writes {qpsk_sym[1], qpsk_sym[0], 14'b0} into the phase register, with qpsk_sym[1] as the MSB. The symbols 00, 01, 10 and 11 give upper-half offsets of 0x0000, 0x4000, 0x8000 and 0xC000.
- R10: The phase register changes only at an edge where its registered enable is low. Changes on qpsk_sym, ph_mode or the phase staging word have no effect at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| host_sel_n | input | 1 | Host bus select, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 2 | Staging register address |
| host_data | input | 16 | Host write data |
| ctr_load_n | input | 1 | Center-frequency load enable, active low |
| ofs_load_n | input | 1 | Offset-frequency load enable, active low |
| ph_load_n | input | 1 | Phase register load enable, active low |
| ph_mode | input | 1 | 1: phase from staging word, 0: phase from symbol pins |
| qpsk_sym | input | 2 | Quadrant symbol, bit 1 is the phase MSB |
| phase_arg | output | 32 | Registered phase argument for the lookup |
| acc_carry_n | output | 1 | Inverted accumulator overflow |

## Verification
A staging write is visible at the edge that samples it. A frequency load enable that is sampled low at edge k reaches phase_arg only after edge k+3, and a phase load reaches it after edge k+2, because the enable register, the target register and the argument register each add one stage. The carry output sits one stage ahead of phase_arg, so each carry is compared against the wrap that phase_arg shows one cycle later. The bench drives inputs on falling edges, samples just before it drives, and waits out these counts, and it judges steady stepping by the difference between consecutive arguments once every load has settled.

// File: rtl/nco_pkg.sv
// Shared definitions for the NCO phase and frequency control block.
// Assumes the host address field is two bits wide.
package nco_pkg;

    // Host staging register select codes
    typedef enum logic [1:0] {
        HA_FREQ_LO = 2'b00,
        HA_FREQ_HI = 2'b01,
        HA_PHASE   = 2'b10,
        HA_RSVD    = 2'b11
    } host_addr_e;

    // Slot numbers of the frequency registers inside the step summer
    localparam int FREQ_CENTER = 0;
    localparam int FREQ_OFFSET = 1;
    localparam int FREQ_COUNT  = 2;

endpackage

// File: rtl/nco_host_stage.sv
// Host staging registers. A write on the narrow host bus lands in one of
// three staging words, picked by the address. Assumes select and write
// strobe are synchronous to clk and the reserved code writes nothing.
module nco_host_stage
    import nco_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             wr_n,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] data,
    output logic [BUS_W-1:0] stage_lo,
    output logic [BUS_W-1:0] stage_hi,
    output logic [BUS_W-1:0] stage_ph
);

    logic       wr_go;
    host_addr_e addr_code;

    // Decode a valid write strobe and type the address
    always_comb begin
        wr_go     = !sel_n && !wr_n;
        addr_code = host_addr_e'(addr);
    end

    // Capture the host word into the addressed staging register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_lo <= '0;
            stage_hi <= '0;
            stage_ph <= '0;
        end else if (wr_go) begin
            case (addr_code)
                HA_FREQ_LO: stage_lo <= data;
                HA_FREQ_HI: stage_hi <= data;
                HA_PHASE:   stage_ph <= data;
                default:    ;
            endcase
        end
    end

    AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n && addr == 2'b11) |=> ($stable(stage_lo) && $stable(stage_hi) && $stable(stage_ph))); // R2

    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> ($stable(stage_lo) && $stable(stage_hi) && $stable(stage_ph))); // R2

endmodule

// File: rtl/nco_freq_regs.sv
// Frequency registers with pipelined active-low load enables. Each enable
// is registered once; a low registered enable copies the staged word into
// its register at every edge. The phase step is the sum of all registers
// modulo 2^WORD_W. Assumes the staged word is stable while loading.
module nco_freq_regs #(
    parameter int WORD_W   = 32,
    parameter int NUM_REGS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] load_n,
    input  logic [WORD_W-1:0]   stage_word,
    output logic [WORD_W-1:0]   step
);

    logic [NUM_REGS-1:0]             en_q;
    logic [NUM_REGS-1:0][WORD_W-1:0] freq_q;

    // Register the active-low load enables
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '1;
        else        en_q <= load_n;
    end

    // Reload each register from staging while its registered enable is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (!en_q[i]) freq_q[i] <= stage_word;
            end
        end
    end

    // Sum all frequency registers into the wrapping phase step
    always_comb begin
        step = '0;
        for (int i = 0; i < NUM_REGS; i++) step = step + freq_q[i];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            en_q[g] |=> $stable(freq_q[g])); // R3
    end

endmodule

// File: rtl/nco_phase_reg.sv
// Phase offset register. Loads through a registered active-low enable,
// either from the host staging word or, in quadrant mode, from the symbol
// pins placed in the top bits with the rest cleared. Assumes the mode and
// symbol inputs are stable at the loading edge.
module nco_phase_reg #(
    parameter int OFS_W = 16,
    parameter int MOD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             mode,
    input  logic [MOD_W-1:0] sym,
    input  logic [OFS_W-1:0] stage_ph,
    output logic [OFS_W-1:0] phase_q
);

    localparam int PAD_W = OFS_W - MOD_W;

    logic             en_q;
    logic [OFS_W-1:0] phase_next;

    // Register the active-low load enable
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= load_n;
    end

    // Pick the phase source: staging word or quadrant symbol
    always_comb begin
        if (mode) phase_next = stage_ph;
        else      phase_next = {sym, {PAD_W{1'b0}}};
    end

    // Load the phase register while the registered enable is low
    always_ff @(posedge clk) begin
        if (!rst_n)     phase_q <= '0;
        else if (!en_q) phase_q <= phase_next;
    end

    AST_PH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(phase_q)); // R10

    AST_QPSK_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !mode) |=> (phase_q[PAD_W-1:0] == '0)); // R9

    AST_QPSK_MSB_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !mode) |=> (phase_q[OFS_W-1 -: MOD_W] == $past(sym))); // R9

endmodule

// File: rtl/nco_phase_acc.sv
// Phase accumulator and phase adder. Adds the step each edge with a
// wrapping sum, registers the inverted overflow, and registers the output
// argument as the accumulator plus an offset on its upper bits. Assumes
// OFS_W is smaller than PHASE_W.
module nco_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int OFS_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] step,
    input  logic [OFS_W-1:0]   phase_ofs,
    output logic [PHASE_W-1:0] phase_arg,
    output logic               carry_n
);

    localparam int LO_W = PHASE_W - OFS_W;

    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W:0]   sum_wide;
    logic [OFS_W-1:0]   arg_hi;

    // Form the accumulator sum with its overflow bit
    always_comb begin
        sum_wide = {1'b0, acc_q} + {1'b0, step};
        arg_hi   = acc_q[PHASE_W-1 -: OFS_W] + phase_ofs;
    end

    // Advance the accumulator and record the inverted overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_n <= 1'b1;
        end else begin
            acc_q   <= sum_wide[PHASE_W-1:0];
            carry_n <= ~sum_wide[PHASE_W];
        end
    end

    // Register the offset phase argument
    always_ff @(posedge clk) begin
        if (!rst_n) phase_arg <= '0;
        else        phase_arg <= {arg_hi, acc_q[LO_W-1:0]};
    end

    AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (carry_n == !(acc_q < $past(acc_q)))); // R6

    AST_ARG_LOW_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_arg[LO_W-1:0] == $past(acc_q[LO_W-1:0]))); // R7

endmodule

// File: rtl/nco_phase_ctrl.sv
// Top of the NCO phase and frequency control block. Host staging feeds a
// center and an offset frequency register and a phase register; their sum
// drives a wrapping phase accumulator whose upper half is offset by the
// phase register to form the lookup argument. Assumes one clock domain.
module nco_phase_ctrl
    import nco_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int MOD_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel_n,
    input  logic               host_wr_n,
    input  logic [1:0]         host_addr,
    input  logic [BUS_W-1:0]   host_data,
    input  logic               ctr_load_n,
    input  logic               ofs_load_n,
    input  logic               ph_load_n,
    input  logic               ph_mode,
    input  logic [MOD_W-1:0]   qpsk_sym,
    output logic [2*BUS_W-1:0] phase_arg,
    output logic               acc_carry_n
);

    localparam int PHASE_W = 2 * BUS_W;

    logic [BUS_W-1:0]      stage_lo;
    logic [BUS_W-1:0]      stage_hi;
    logic [BUS_W-1:0]      stage_ph;
    logic [PHASE_W-1:0]    stage_word;
    logic [FREQ_COUNT-1:0] freq_load_n;
    logic [PHASE_W-1:0]    step;
    logic [BUS_W-1:0]      phase_q;

    // Join the staged halves and order the frequency enables
    always_comb begin
        stage_word                = {stage_hi, stage_lo};
        freq_load_n               = '1;
        freq_load_n[FREQ_CENTER]  = ctr_load_n;
        freq_load_n[FREQ_OFFSET]  = ofs_load_n;
    end

    nco_host_stage #(.BUS_W(BUS_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (host_sel_n),
        .wr_n     (host_wr_n),
        .addr     (host_addr),
        .data     (host_data),
        .stage_lo (stage_lo),
        .stage_hi (stage_hi),
        .stage_ph (stage_ph)
    );

    nco_freq_regs #(.WORD_W(PHASE_W), .NUM_REGS(FREQ_COUNT)) u_freq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_n     (freq_load_n),
        .stage_word (stage_word),
        .step       (step)
    );

    nco_phase_reg #(.OFS_W(BUS_W), .MOD_W(MOD_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (ph_load_n),
        .mode     (ph_mode),
        .sym      (qpsk_sym),
        .stage_ph (stage_ph),
        .phase_q  (phase_q)
    );

    nco_phase_acc #(.PHASE_W(PHASE_W), .OFS_W(BUS_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .phase_ofs (phase_q),
        .phase_arg (phase_arg),
        .carry_n   (acc_carry_n)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (phase_arg == '0 && acc_carry_n)); // R1

endmodule

// File: tb/nco_phase_ctrl_bench.sv
`timescale 1ns/1ps
module nco_phase_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_sel_n, host_wr_n;
    logic [1:0]  host_addr;
    logic [15:0] host_data;
    logic        ctr_load_n, ofs_load_n, ph_load_n;
    logic        ph_mode;
    logic [1:0]  qpsk_sym;
    logic [31:0] phase_arg;
    logic        acc_carry_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    nco_phase_ctrl u_nco_phase_ctrl (
        .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_wr_n(host_wr_n),
        .host_addr(host_addr), .host_data(host_data), .ctr_load_n(ctr_load_n),
        .ofs_load_n(ofs_load_n), .ph_load_n(ph_load_n), .ph_mode(ph_mode),
        .qpsk_sym(qpsk_sym), .phase_arg(phase_arg), .acc_carry_n(acc_carry_n)
    );

    typedef struct packed {
        logic [31:0] ctr;
        logic [31:0] ofs;
        logic [15:0] ph;
        logic        mode;
        logic [1:0]  sym;
        logic [31:0] exp0;
        logic [31:0] step;
    } vec_t;

    // center, offset, phase word, mode, symbol, argument with zero step, step
    localparam vec_t VECS [6] = '{
        '{32'h0100_0000, 32'h0000_0010, 16'h1234, 1'b1, 2'b00, 32'h1234_0000, 32'h0100_0010},
        '{32'h4000_0000, 32'hC000_0000, 16'hFFFF, 1'b1, 2'b00, 32'hFFFF_0000, 32'h0000_0000},
        '{32'h7FFF_FFFF, 32'h0000_0001, 16'hABCD, 1'b0, 2'b01, 32'h4000_0000, 32'h8000_0000},
        '{32'h1111_1111, 32'h2222_2222, 16'h0000, 1'b0, 2'b10, 32'h8000_0000, 32'h3333_3333},
        '{32'hFFFF_0000, 32'h0001_0001, 16'h5555, 1'b0, 2'b11, 32'hC000_0000, 32'h0000_0001},
        '{32'h0000_0000, 32'hDEAD_BEEF, 16'h0001, 1'b1, 2'b00, 32'h0001_0000, 32'hDEAD_BEEF}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic host_write(logic [1:0] a, logic [15:0] d);
        host_sel_n = 1'b0; host_wr_n = 1'b0; host_addr = a; host_data = d;
        tick(1);
        host_sel_n = 1'b1; host_wr_n = 1'b1;
    endtask

    // which: 0 center, 1 offset, 2 phase
    task automatic pulse_load(int which);
        if (which == 0) ctr_load_n = 1'b0;
        else if (which == 1) ofs_load_n = 1'b0;
        else ph_load_n = 1'b0;
        tick(1);
        ctr_load_n = 1'b1; ofs_load_n = 1'b1; ph_load_n = 1'b1;
    endtask

    task automatic load_freq(int which, logic [31:0] v);
        host_write(2'b00, v[15:0]);
        host_write(2'b01, v[31:16]);
        pulse_load(which);
    endtask

    // Check a run of consecutive argument differences against the step
    task automatic check_step(string req, logic [31:0] s, int n);
        logic [31:0] prev;
        prev = phase_arg;
        for (int k = 0; k < n; k++) begin
            tick(1);
            chk(req, phase_arg - prev, s);
            prev = phase_arg;
        end
    endtask

    // Carry in a cycle must match a wrap of the argument one cycle later
    task automatic check_carry(int n);
        logic [31:0] a_now;
        logic        c_now;
        for (int k = 0; k < n; k++) begin
            a_now = phase_arg;
            c_now = acc_carry_n;
            tick(1);
            chk("R6", {31'b0, c_now}, {31'b0, !(phase_arg < a_now)});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; host_sel_n = 1'b1; host_wr_n = 1'b1; host_addr = 2'b00;
        host_data = '0; ctr_load_n = 1'b1; ofs_load_n = 1'b1; ph_load_n = 1'b1;
        ph_mode = 1'b1; qpsk_sym = 2'b00;
        tick(1);

        // Vector table: phase source first with zero step, then the step
        for (int i = 0; i < 6; i++) begin
            do_reset();
            chk("R1", phase_arg, 32'h0);
            chk("R1", {31'b0, acc_carry_n}, 32'h1);
            ph_mode  = VECS[i].mode;
            qpsk_sym = VECS[i].sym;
            host_write(2'b10, VECS[i].ph);
            pulse_load(2);
            tick(2);
            chk(VECS[i].mode ? "R8" : "R9", phase_arg, VECS[i].exp0);
            load_freq(0, VECS[i].ctr);
            load_freq(1, VECS[i].ofs);
            tick(4);
            check_step("R5", VECS[i].step, 3);
        end

        // R3: load latency of a frequency register
        ph_mode = 1'b1;
        do_reset();
        load_freq(0, 32'h0000_1000);
        tick(2);
        chk("R3", phase_arg, 32'h0);
        tick(1);
        chk("R3", phase_arg, 32'h0000_1000);
        tick(1);
        chk("R3", phase_arg, 32'h0000_2000);

        // R2: reserved address and deselected writes are ignored
        do_reset();
        host_write(2'b00, 16'h0005);
        host_write(2'b01, 16'h0000);
        host_write(2'b11, 16'hFFFF);
        host_sel_n = 1'b1; host_wr_n = 1'b0; host_addr = 2'b01; host_data = 16'hFFFF;
        tick(1);
        host_addr = 2'b10;
        tick(1);
        host_wr_n = 1'b1;
        pulse_load(2);
        tick(2);
        chk("R2", phase_arg, 32'h0);
        pulse_load(0);
        tick(4);
        check_step("R2", 32'h0000_0005, 2);

        // R4: held enable keeps reloading; R3: released enable holds
        do_reset();
        host_write(2'b00, 16'h0010);
        host_write(2'b01, 16'h0000);
        ctr_load_n = 1'b0;
        tick(4);
        check_step("R4", 32'h0000_0010, 2);
        host_write(2'b00, 16'h0020);
        tick(4);
        check_step("R4", 32'h0000_0020, 2);
        ctr_load_n = 1'b1;
        host_write(2'b00, 16'h0040);
        tick(4);
        check_step("R3", 32'h0000_0020, 2);

        // R6: carry against argument wraps, two step sizes
        do_reset();
        load_freq(0, 32'h8000_0000);
        load_freq(1, 32'h4000_0000);
        tick(4);
        check_carry(8);
        do_reset();
        load_freq(0, 32'hFFFF_FFFF);
        tick(4);
        check_carry(6);

        // R7: argument is accumulator plus shifted phase; step 3 with 0x0100
        do_reset();
        ph_mode = 1'b1;
        host_write(2'b10, 16'h0100);
        pulse_load(2);
        tick(2);
        load_freq(0, 32'h0000_0003);
        tick(2);
        chk("R7", phase_arg, 32'h0100_0000);
        tick(1);
        chk("R7", phase_arg, 32'h0100_0003);
        tick(1);
        chk("R7", phase_arg, 32'h0100_0006);

        // R10: phase register ignores pins and staging without a load
        do_reset();
        ph_mode  = 1'b0;
        qpsk_sym = 2'b01;
        pulse_load(2);
        tick(2);
        chk("R9", phase_arg, 32'h4000_0000);
        qpsk_sym = 2'b11;
        ph_mode  = 1'b1;
        tick(4);
        chk("R10", phase_arg, 32'h4000_0000);
        host_write(2'b10, 16'h7777);
        tick(3);
        chk("R10", phase_arg, 32'h4000_0000);

        // R1: reset in mid run clears everything
        load_freq(0, 32'h0123_4567);
        tick(5);
        rst_n = 1'b0;
        tick(1);
        chk("R1", phase_arg, 32'h0);
        chk("R1", {31'b0, acc_carry_n}, 32'h1);
        rst_n = 1'b1;
        tick(4);
        chk("R1", phase_arg, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule